// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked system and an asynchronous static RAM with 20 address lines, an 8-bit data bus, an active-low select, an active-high select, an active-low output enable and an active-low write enable. The host presents one read or one write at a time with `req_valid`, and holds the address, write flag and write data steady until the controller pulses `req_ready`. On a read, the returned byte is on `rsp_rdata` in the same cycle as that pulse. Every strobe on the RAM side comes from a register, so the RAM pins never glitch.

Each timing limit of the RAM is a nanosecond parameter. The block rounds it up to whole clock periods. `SLOW_GRADE` chooses between the 55 ns and the 70 ns timing sets. The data bus is split into an output value, an output enable and an input value, so the bidirectional pad can be built outside this block.

Raising `standby_req` parks the RAM deselected for battery-backed retention. When it is released, the controller waits out the retention recovery time before it serves any access.

Top module: `sram_ctl`

## Requirements
- R1: Reset (asynchronous, active low) leaves `mem_sel_n`=1, `mem_sel`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0 and `req_ready`=0. This holds even when reset arrives in the middle of a write.
- R2: Each interval converts to cycles as ceil(ns / `CLK_PERIOD_NS`), with a minimum of 1. With `SLOW_GRADE`=0 the set is: cycle 55, address access 55, OE access 25, write pulse 40, select/address-to-end-of-write 45, data setup 25, output release 20. With `SLOW_GRADE`=1 the values become 70, 70, 35, 50, 60, 30 and 25.
- R3: A read holds `mem_oe_n` low, with both selects active and `mem_we_n` high, for exactly N_RD = max(cycle, address access, OE access) consecutive cycles. The byte on `mem_dq_i` in the last of those cycles appears on `rsp_rdata` in the ready cycle. `mem_addr` keeps the request address throughout.
- R4: A write holds `mem_we_n` low for exactly N_WP = max(write pulse, select-to-end, address-to-end, data setup + 1) cycles. Both selects become active on the same edge that `mem_we_n` falls and stay active past its rise, so the WE edges alone mark the start and end of the write.
- R5: `mem_dq_oe` is high only from the cycle after `mem_we_n` falls until the cycle after it rises, which is N_WP cycles in total. It is never high while `mem_oe_n` is low.
- R6: A write accepted in an idle cycle raises `req_ready` in the (N_WP + N_WT + 1)-th cycle after the accepting edge, where N_WT = max(1, cycles(write cycle) − N_WP).
- R7: A read that directly follows a write keeps `mem_oe_n` high, with the selects active, for N_TA = cycles(output release) before its read window, and so becomes ready in cycle N_TA + N_RD + 1. A read after a read becomes ready in cycle N_RD + 1.
- R8: `req_ready` is high for exactly one cycle per transaction. Only one transaction is in flight, and a request is taken only while the controller is idle.
- R9: While `standby_req` is high, both selects stay deasserted, OE and WE stay high, the bus is not driven and no request completes.
- R10: After `standby_req` falls, the RAM stays deselected for N_RDR = cycles(`T_RDR_NS`) before a request is accepted. A held read therefore becomes ready in cycle N_RDR + N_RD + 2 after the falling edge.
- R11: If `standby_req` and a request arrive in the same idle cycle, standby wins and the request waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host has a transaction pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write byte |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Byte returned by the last read |
| standby_req | input | 1 | Request retention standby |
| mem_addr | output | AW | RAM address lines |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | DW | Data driven towards the RAM |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | DW | Data seen on the RAM pads |

## Verification
The hardest state to reach is the collision of standby with work in progress. A read request and `standby_req` are raised in the same idle cycle, the request is held through a long standby, and the release of standby is then timed against the recovery counter. The read-after-write turnaround is reached by ordering the stimulus table so that reads directly follow writes, as well as other reads. A bench RAM model returns garbage until the address access time has elapsed, so a capture that comes too early cannot read the right byte. A reset is also forced while WE is low, to show that the pins drop cleanly mid-write.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_READ,
        ST_WRITE,
        ST_WTAIL,
        ST_DONE,
        ST_STBY,
        ST_RECOV
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       sel_n;
        logic       sel;
        logic       oe_n;
        logic       we_n;
        logic       drv;
        logic       rdy;
        logic       after_wr;
    } seq_regs_t;

    // whole clock periods covering a nanosecond interval, never below one
    function automatic int cyc_of_ns(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // final cycle of a loaded interval
    assign expire = (tmr_q.cnt == CW'(1));

endmodule

// File: rtl/sram_ctl_datapath.sv
`timescale 1ns/1ps
module sram_ctl_datapath #(
    parameter int AW = 20,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_dq_i,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_o,
    output logic [DW-1:0] rsp_rdata
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] wdat;
        logic [DW-1:0] rdat;
    } dp_regs_t;

    dp_regs_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.addr = req_addr;
            dp_d.wdat = req_wdata;
        end
        if (capture) begin
            dp_d.rdat = mem_dq_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign mem_addr  = dp_q.addr;
    assign mem_dq_o  = dp_q.wdat;
    assign rsp_rdata = dp_q.rdat;

    // a new request is never latched while a read result is being taken
    assert_no_accept_on_capture_R8: assert property (
        @(posedge clk) disable iff (!rst_n) capture |-> !accept
    );

endmodule

// File: rtl/sram_ctl_fsm.sv
`timescale 1ns/1ps
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CW    = 8,
    parameter int N_RD  = 6,
    parameter int N_WP  = 5,
    parameter int N_WT  = 1,
    parameter int N_TA  = 2,
    parameter int N_RDR = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          standby_req,
    input  logic          tmr_expire,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          accept,
    output logic          capture,
    output logic          sel_n,
    output logic          sel,
    output logic          oe_n,
    output logic          we_n,
    output logic          drv,
    output logic          rdy
);
    localparam seq_regs_t SEQ_RST = '{
        st:       ST_IDLE,
        sel_n:    1'b1,
        sel:      1'b0,
        oe_n:     1'b1,
        we_n:     1'b1,
        drv:      1'b0,
        rdy:      1'b0,
        after_wr: 1'b0
    };

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        seq_d.rdy = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        accept    = 1'b0;
        capture   = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (standby_req) begin
                    seq_d.st = ST_STBY;
                end else if (req_valid) begin
                    accept      = 1'b1;
                    seq_d.sel_n = 1'b0;
                    seq_d.sel   = 1'b1;
                    tmr_load    = 1'b1;
                    if (req_write) begin
                        seq_d.st   = ST_WRITE;
                        seq_d.we_n = 1'b0;
                        tmr_val    = CW'(N_WP);
                    end else if (seq_q.after_wr) begin
                        seq_d.st = ST_TURN;
                        tmr_val  = CW'(N_TA);
                    end else begin
                        seq_d.st   = ST_READ;
                        seq_d.oe_n = 1'b0;
                        tmr_val    = CW'(N_RD);
                    end
                end
            end
            ST_TURN: begin
                if (tmr_expire) begin
                    seq_d.st       = ST_READ;
                    seq_d.oe_n     = 1'b0;
                    seq_d.after_wr = 1'b0;
                    tmr_load       = 1'b1;
                    tmr_val        = CW'(N_RD);
                end
            end
            ST_READ: begin
                if (tmr_expire) begin
                    capture        = 1'b1;
                    seq_d.oe_n     = 1'b1;
                    seq_d.sel_n    = 1'b1;
                    seq_d.sel      = 1'b0;
                    seq_d.after_wr = 1'b0;
                    seq_d.rdy      = 1'b1;
                    seq_d.st       = ST_DONE;
                end
            end
            ST_WRITE: begin
                seq_d.drv = 1'b1;
                if (tmr_expire) begin
                    seq_d.we_n     = 1'b1;
                    seq_d.after_wr = 1'b1;
                    seq_d.st       = ST_WTAIL;
                    tmr_load       = 1'b1;
                    tmr_val        = CW'(N_WT);
                end
            end
            ST_WTAIL: begin
                seq_d.drv = 1'b0;
                if (tmr_expire) begin
                    seq_d.sel_n = 1'b1;
                    seq_d.sel   = 1'b0;
                    seq_d.rdy   = 1'b1;
                    seq_d.st    = ST_DONE;
                end
            end
            ST_DONE: begin
                seq_d.st = ST_IDLE;
            end
            ST_STBY: begin
                if (!standby_req) begin
                    seq_d.st = ST_RECOV;
                    tmr_load = 1'b1;
                    tmr_val  = CW'(N_RDR);
                end
            end
            ST_RECOV: begin
                if (tmr_expire) seq_d.st = ST_IDLE;
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign sel_n = seq_q.sel_n;
    assign sel   = seq_q.sel;
    assign oe_n  = seq_q.oe_n;
    assign we_n  = seq_q.we_n;
    assign drv   = seq_q.drv;
    assign rdy   = seq_q.rdy;

    assert_write_selected_R4: assert property (
        @(posedge clk) disable iff (!rst_n) !seq_q.we_n |-> (!seq_q.sel_n && seq_q.sel)
    );

    assert_write_ends_on_we_R4: assert property (
        @(posedge clk) disable iff (!rst_n) $rose(seq_q.we_n) |-> (!seq_q.sel_n && seq_q.sel)
    );

    assert_read_strobes_R3: assert property (
        @(posedge clk) disable iff (!rst_n) !seq_q.oe_n |-> (!seq_q.sel_n && seq_q.sel && seq_q.we_n)
    );

    assert_no_drive_with_oe_R5: assert property (
        @(posedge clk) disable iff (!rst_n) seq_q.drv |-> seq_q.oe_n
    );

    assert_drive_window_R5: assert property (
        @(posedge clk) disable iff (!rst_n) seq_q.drv |-> (!seq_q.we_n || $past(!seq_q.we_n))
    );

    assert_ready_single_R8: assert property (
        @(posedge clk) disable iff (!rst_n) seq_q.rdy |=> !seq_q.rdy
    );

    assert_standby_deselect_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_STBY || seq_q.st == ST_RECOV) |-> (seq_q.sel_n && !seq_q.sel && seq_q.oe_n && seq_q.we_n)
    );

    assert_standby_priority_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && standby_req) |=> (seq_q.st == ST_STBY)
    );

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int AW            = 20,
    parameter int DW            = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter bit SLOW_GRADE    = 1'b0,
    parameter int T_RDR_NS      = 5_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic [DW-1:0] rsp_rdata,
    input  logic          standby_req,
    output logic [AW-1:0] mem_addr,
    output logic          mem_sel_n,
    output logic          mem_sel,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);
    // speed grade timing set, nanoseconds
    localparam int T_RC  = SLOW_GRADE ? 70 : 55;
    localparam int T_AA  = SLOW_GRADE ? 70 : 55;
    localparam int T_OE  = SLOW_GRADE ? 35 : 25;
    localparam int T_WC  = SLOW_GRADE ? 70 : 55;
    localparam int T_WP  = SLOW_GRADE ? 50 : 40;
    localparam int T_CW  = SLOW_GRADE ? 60 : 45;
    localparam int T_AW  = SLOW_GRADE ? 60 : 45;
    localparam int T_DW  = SLOW_GRADE ? 30 : 25;
    localparam int T_OHZ = SLOW_GRADE ? 25 : 20;

    // cycle counts
    localparam int N_RD  = imax(cyc_of_ns(T_RC, CLK_PERIOD_NS),
                                imax(cyc_of_ns(T_AA, CLK_PERIOD_NS), cyc_of_ns(T_OE, CLK_PERIOD_NS)));
    localparam int N_WP  = imax(imax(cyc_of_ns(T_WP, CLK_PERIOD_NS), cyc_of_ns(T_CW, CLK_PERIOD_NS)),
                                imax(cyc_of_ns(T_AW, CLK_PERIOD_NS), cyc_of_ns(T_DW, CLK_PERIOD_NS) + 1));
    localparam int N_WT  = imax(1, cyc_of_ns(T_WC, CLK_PERIOD_NS) - N_WP);
    localparam int N_TA  = cyc_of_ns(T_OHZ, CLK_PERIOD_NS);
    localparam int N_RDR = cyc_of_ns(T_RDR_NS, CLK_PERIOD_NS);
    localparam int N_MAX = imax(imax(N_RD, N_WP), imax(imax(N_WT, N_TA), N_RDR));
    localparam int CW    = $clog2(N_MAX + 1);

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expire;
    logic          accept;
    logic          capture;

    sram_ctl_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    sram_ctl_fsm #(
        .CW    (CW),
        .N_RD  (N_RD),
        .N_WP  (N_WP),
        .N_WT  (N_WT),
        .N_TA  (N_TA),
        .N_RDR (N_RDR)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .standby_req (standby_req),
        .tmr_expire  (tmr_expire),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .accept      (accept),
        .capture     (capture),
        .sel_n       (mem_sel_n),
        .sel         (mem_sel),
        .oe_n        (mem_oe_n),
        .we_n        (mem_we_n),
        .drv         (mem_dq_oe),
        .rdy         (req_ready)
    );

    sram_ctl_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_dq_i  (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .rsp_rdata (rsp_rdata)
    );

endmodule

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb;
    localparam int CLK_NS = 10;
    localparam int RDR_NS = 95;
    localparam int AW     = 20;
    localparam int DW     = 8;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_NS - 1) / CLK_NS;
        if (c < 1) c = 1;
        return c;
    endfunction

    // expected counts for the fast grade (R2)
    localparam int E_RD  = 6;   // max(55,55,25 ns) -> 6
    localparam int E_WP  = 5;   // max(40,45,45,25ns+1) -> 5
    localparam int E_WT  = 1;   // max(1, 6-5)
    localparam int E_TA  = 2;   // 20 ns
    localparam int E_RDR = 10;  // 95 ns rounds up

    typedef struct packed {
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] dat;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 20'h00012, 8'hA5},
        '{1'b1, 20'hFFFFF, 8'h3C},
        '{1'b0, 20'h00012, 8'hA5},
        '{1'b0, 20'hFFFFF, 8'h3C},
        '{1'b1, 20'h00001, 8'h00},
        '{1'b1, 20'h00001, 8'hFF},
        '{1'b0, 20'h00001, 8'hFF},
        '{1'b0, 20'h00030, 8'h00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic [DW-1:0] rsp_rdata;
    logic          standby_req = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_o;
    logic [DW-1:0] mem_dq_i;

    always #(CLK_NS/2) clk = ~clk;

    sram_ctl #(
        .AW(AW), .DW(DW), .CLK_PERIOD_NS(CLK_NS), .SLOW_GRADE(1'b0), .T_RDR_NS(RDR_NS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .standby_req(standby_req), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i)
    );

    // RAM model: data only valid once the access time has passed
    logic [DW-1:0] ram [64];
    int rd_age = 0;
    wire rd_act = !mem_sel_n && mem_sel && !mem_oe_n && mem_we_n;
    initial for (int i = 0; i < 64; i++) ram[i] = '0;
    always @(posedge clk) rd_age <= rd_act ? rd_age + 1 : 0;
    assign mem_dq_i = (rd_act && rd_age >= E_RD - 1) ? ram[mem_addr[5:0]] : 8'hEE;
    always @(posedge mem_we_n)
        if (rst_n === 1'b1 && !mem_sel_n && mem_sel)
            ram[mem_addr[5:0]] <= mem_dq_oe ? mem_dq_o : 8'hDE;

    // pin monitor
    int we_run = 0, oe_run = 0, drv_run = 0;
    int we_w = 0, oe_w = 0, drv_w = 0;
    int bad_sel = 0, bad_drv = 0;
    logic prev_we_n = 1'b1;
    always @(negedge clk) begin
        if (!rst_n) begin
            we_run = 0; oe_run = 0; drv_run = 0; prev_we_n = 1'b1;
        end else begin
            if (!mem_we_n) we_run++; else if (we_run > 0) begin we_w = we_run; we_run = 0; end
            if (!mem_oe_n) oe_run++; else if (oe_run > 0) begin oe_w = oe_run; oe_run = 0; end
            if (mem_dq_oe) drv_run++; else if (drv_run > 0) begin drv_w = drv_run; drv_run = 0; end
            if ((!mem_we_n || !mem_oe_n) && (mem_sel_n || !mem_sel)) bad_sel++;
            if (mem_dq_oe && (!mem_oe_n || (mem_we_n && prev_we_n))) bad_drv++;
            prev_we_n = mem_we_n;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // one transaction from idle; returns latency and read data
    task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] dat,
                         output int lat, output logic [DW-1:0] got, output logic [AW-1:0] seen_addr);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat;
        lat = 0;
        while (lat < 400) begin
            @(negedge clk);
            lat++;
            if (req_ready) break;
        end
        got = rsp_rdata;
        seen_addr = mem_addr;
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int lat;
        logic [DW-1:0] got;
        logic [AW-1:0] sa;
        logic prev_wr;
        int rdy_seen, oe_seen, dsel_bad;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(mem_sel_n === 1'b1 && mem_sel === 1'b0, "R1 selects in reset", {mem_sel_n, mem_sel}, 2);
        chk(mem_oe_n === 1'b1 && mem_we_n === 1'b1, "R1 strobes in reset", {mem_oe_n, mem_we_n}, 3);
        chk(mem_dq_oe === 1'b0 && req_ready === 1'b0, "R1 drive/ready in reset", {mem_dq_oe, req_ready}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2..R8 stimulus table
        prev_wr = 1'b0;
        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i].wr, VEC[i].addr, VEC[i].dat, lat, got, sa);
            chk(req_ready == 1'b0, "R8 ready single pulse", req_ready, 0);
            chk(sa == VEC[i].addr, "R3 R4 address held", sa, VEC[i].addr);
            if (VEC[i].wr) begin
                chk(lat == E_WP + E_WT + 1, "R6 R2 write latency", lat, E_WP + E_WT + 1);
                chk(we_w == E_WP, "R4 write pulse width", we_w, E_WP);
                chk(drv_w == E_WP, "R5 drive window width", drv_w, E_WP);
            end else begin
                chk(lat == (prev_wr ? E_TA : 0) + E_RD + 1, "R7 R3 read latency", lat,
                    (prev_wr ? E_TA : 0) + E_RD + 1);
                chk(oe_w == E_RD, "R3 OE window width", oe_w, E_RD);
                chk(got == VEC[i].dat, "R3 read data", got, VEC[i].dat);
            end
            prev_wr = VEC[i].wr;
        end
        chk(bad_sel == 0, "R4 strobe without both selects", bad_sel, 0);
        chk(bad_drv == 0, "R5 drive outside window", bad_drv, 0);

        // R11 standby and request together, R9 held off, R10 recovery
        @(negedge clk);
        standby_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00012;
        rdy_seen = 0; oe_seen = 0; dsel_bad = 0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (req_ready) rdy_seen++;
            if (!mem_oe_n || !mem_we_n || mem_dq_oe) oe_seen++;
            if (!mem_sel_n || mem_sel) dsel_bad++;
        end
        chk(oe_seen == 0, "R11 request not started with standby", oe_seen, 0);
        chk(rdy_seen == 0, "R9 no completion in standby", rdy_seen, 0);
        chk(dsel_bad == 0, "R9 selects parked in standby", dsel_bad, 0);
        standby_req = 1'b0;
        lat = 0; dsel_bad = 0;
        while (lat < 400) begin
            @(negedge clk);
            lat++;
            if (lat <= cyc(RDR_NS) && (!mem_sel_n || mem_sel)) dsel_bad++;
            if (req_ready) break;
        end
        got = rsp_rdata;
        req_valid = 1'b0;
        chk(dsel_bad == 0, "R10 deselected during recovery", dsel_bad, 0);
        chk(lat == E_RDR + E_RD + 2, "R10 R2 recovery latency", lat, E_RDR + E_RD + 2);
        chk(got == 8'hA5, "R10 read after recovery", got, 8'hA5);
        @(negedge clk);

        // R1 reset in the middle of a write
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00002; req_wdata = 8'h77;
        repeat (3) @(negedge clk);
        chk(mem_we_n == 1'b0, "R4 write strobe active", mem_we_n, 0);
        rst_n = 1'b0;
        req_valid = 1'b0;
        #1;
        chk(mem_we_n === 1'b1 && mem_sel_n === 1'b1 && mem_sel === 1'b0, "R1 mid-write reset pins",
            {mem_we_n, mem_sel_n, mem_sel}, 6);
        chk(mem_dq_oe === 1'b0 && mem_oe_n === 1'b1, "R1 mid-write reset bus", {mem_dq_oe, mem_oe_n}, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_op(1'b0, 20'h00012, 8'h00, lat, got, sa);
        chk(lat == E_RD + 1, "R1 R7 read after reset", lat, E_RD + 1);
        chk(got == 8'hA5, "R3 data after reset", got, 8'hA5);

        finish_run();
    end

endmodule